// File: doc/BRIEF.md
# Unlock-Protected Data EEPROM Controller

This block fronts a small byte-addressable data store with four bus-visible registers: a location pointer, a data byte, a control/status register and a write-only key register. A CPU reaches them over a simple bus that carries one access per clock. Reads of the store are requested through a control bit and land in the data register one clock later. The storage itself is modelled as an internal register array.

Programming a byte is deliberately hard to trigger by accident. Software must arm a permanent enable bit. It must then place two fixed key bytes into the key register with exact clock spacing, and finally request the write at the same spacing. Each cell write occupies a fixed number of clocks. The target location and value are captured at the moment the write is accepted. When the write ends, a sticky completion flag is raised and, if enabled, an interrupt.

Top module: `nvd_ctrl`

## Requirements
- R1: After reset every register reads 0x00, the store holds 0x00 at every location and `irq` is low. Bus register offsets: 0 = pointer, 1 = data, 2 = control, 3 = key (reads 0x00).
- R2: A control write with bit 0 (RD) set copies the byte at the pointer into the data register, readable on the next clock. RD always reads back as 0.
- R3: The data register keeps its value until the next accepted read or a software write to offset 1. A finishing cell write does not change it.
- R4: A write is accepted only after this sequence: 0x55 to the key register, then 0xAA to the key register exactly STEP_GAP clocks later, then a control write with bit 1 (WR) exactly STEP_GAP clocks after that. A wrong key value, a different spacing or any other bus access in between returns the sequence to its start, and the WR request is rejected.
- R5: WR is accepted only if the enable bit (control bit 2) was already 1 before that control write.
- R6: An accepted write keeps control bit 1 at 1 for WR_CYCLES clocks. It then clears that bit, stores the byte and sets the done flag (control bit 4).
- R7: Clearing the enable bit during a write does not stop the write. Hardware never clears the enable bit.
- R8: The pointer and data captured at acceptance are written, even if software changes either register during the write.
- R9: During a write, RD requests are ignored and key writes do not advance the sequence.
- R10: The done flag stays set until a control write with bit 4 = 0. `irq` equals the done flag ANDed with control bit 5 (interrupt enable).
- R11: A rejected WR request (while no write is running) sets the error flag (control bit 3). A control write with bit 3 = 0 clears it. WR requests made during a running write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this clock |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the register at `bus_addr` (combinational) |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the controller with a 16-byte store, WR_CYCLES = 5 and STEP_GAP = 2. The short write time makes the exact clock where the write bit drops and the done flag rises easy to observe, and it lets the bench reach the end of a write a few accesses after starting one. A key spacing of two leaves one idle slot between steps. That slot is what makes both the early-step and the interposed-access rejections reachable, alongside late requests, wrong key values and writes with the enable bit clear.

// File: rtl/nvd_pkg.sv
// Shared definitions for the data EEPROM controller: register offsets,
// control bit positions, key values and the key-sequence state type.
package nvd_pkg;
    localparam logic [1:0] OFS_PTR  = 2'd0;
    localparam logic [1:0] OFS_DATA = 2'd1;
    localparam logic [1:0] OFS_CTRL = 2'd2;
    localparam logic [1:0] OFS_KEY  = 2'd3;

    localparam int CB_RD   = 0;
    localparam int CB_WR   = 1;
    localparam int CB_EN   = 2;
    localparam int CB_ERR  = 3;
    localparam int CB_DONE = 4;
    localparam int CB_IE   = 5;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_ONE  = 2'd1,
        KS_TWO  = 2'd2
    } key_state_t;
endpackage

// File: rtl/nvd_keyseq.sv
// Timed two-key sequence tracker. Counts clocks since the last accepted
// step; the next step is legal only when exactly STEP_GAP clocks have passed.
// Any other bus access, a late step or a running write returns it to idle.
// Assumes STEP_GAP >= 1 and at most one bus access per clock.
module nvd_keyseq
    import nvd_pkg::*;
#(
    parameter int STEP_GAP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_act,
    input  logic       key_wr,
    input  logic [7:0] key_val,
    input  logic       busy,
    output logic       armed
);
    localparam int CW = $clog2(STEP_GAP + 1);
    localparam logic [CW-1:0] GAP = CW'(STEP_GAP);

    key_state_t    state;
    logic [CW-1:0] gap_cnt;
    logic          on_time;

    assign on_time = (gap_cnt == GAP);
    assign armed   = (state == KS_TWO) && on_time;

    // Advance the key sequence and its spacing counter.
    always_ff @(posedge clk) begin
        if (!rst_n || busy) begin
            state   <= KS_IDLE;
            gap_cnt <= '0;
        end else begin
            unique case (state)
                KS_IDLE: begin
                    if (key_wr && key_val == KEY_FIRST) begin
                        state   <= KS_ONE;
                        gap_cnt <= CW'(1);
                    end
                end
                KS_ONE: begin
                    if (bus_act) begin
                        if (key_wr && key_val == KEY_SECOND && on_time) begin
                            state   <= KS_TWO;
                            gap_cnt <= CW'(1);
                        end else begin
                            state <= KS_IDLE;
                        end
                    end else if (gap_cnt >= GAP) begin
                        state <= KS_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt + CW'(1);
                    end
                end
                default: begin
                    if (bus_act || gap_cnt >= GAP) begin
                        state <= KS_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt + CW'(1);
                    end
                end
            endcase
        end
    end

    // R4
    second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KS_TWO && $past(state) != KS_TWO) |-> $past(key_wr && key_val == KEY_SECOND));

    // R9
    idle_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> state == KS_IDLE);
endmodule

// File: rtl/nvd_wtimer.sv
// Cell-write sequencer: captures target and value on start, holds them
// for WR_CYCLES clocks and pulses done in the last busy clock.
// Assumes start is only raised while not busy and WR_CYCLES >= 1.
module nvd_wtimer #(
    parameter int AW        = 6,
    parameter int WR_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] ptr_in,
    input  logic [7:0]    data_in,
    output logic          busy,
    output logic          done_pulse,
    output logic [AW-1:0] wr_ptr,
    output logic [7:0]    wr_data
);
    localparam int TW = $clog2(WR_CYCLES + 1);

    logic [TW-1:0] left;

    assign done_pulse = busy && (left == '0);

    // Run the write timer and hold the captured target/value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            left    <= '0;
            wr_ptr  <= '0;
            wr_data <= '0;
        end else if (start && !busy) begin
            busy    <= 1'b1;
            left    <= TW'(WR_CYCLES - 1);
            wr_ptr  <= ptr_in;
            wr_data <= data_in;
        end else if (busy) begin
            if (left == '0) busy <= 1'b0;
            else            left <= left - TW'(1);
        end
    end

    // R8
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(wr_ptr) && $stable(wr_data)));

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/nvd_store.sv
// Byte array standing in for the nonvolatile cells: one combinational read
// port, one clocked write port. Cleared by reset to give a known image.
module nvd_store #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    assign rdata = cells[raddr];

    // Clear on reset, otherwise store the finished byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/nvd_ctrl.sv
// Register front end of the protected data EEPROM. Decodes the bus, holds
// pointer/data/control state and ties the key sequencer, write timer and
// store together. Assumes DEPTH is a power of two no larger than 256.
module nvd_ctrl
    import nvd_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int WR_CYCLES = 16,
    parameter int STEP_GAP  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_write,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] ptr_q;
    logic [7:0]    data_q;
    logic          en_q, err_q, done_q, ie_q;
    logic          ctrl_wr, key_wr, wr_req, rd_req, start, reject;
    logic          armed, busy, done_pulse;
    logic [AW-1:0] wr_ptr;
    logic [7:0]    wr_data, cell_q;

    assign ctrl_wr = bus_sel && bus_write && bus_addr == OFS_CTRL;
    assign key_wr  = bus_sel && bus_write && bus_addr == OFS_KEY;
    assign wr_req  = ctrl_wr && bus_wdata[CB_WR];
    assign start   = wr_req && en_q && armed && !busy;
    assign reject  = wr_req && !busy && !start;
    assign rd_req  = ctrl_wr && bus_wdata[CB_RD] && !busy;
    assign irq     = done_q && ie_q;

    nvd_keyseq #(.STEP_GAP(STEP_GAP)) u_keys (
        .clk(clk), .rst_n(rst_n), .bus_act(bus_sel), .key_wr(key_wr),
        .key_val(bus_wdata), .busy(busy), .armed(armed)
    );

    nvd_wtimer #(.AW(AW), .WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .ptr_in(ptr_q),
        .data_in(data_q), .busy(busy), .done_pulse(done_pulse),
        .wr_ptr(wr_ptr), .wr_data(wr_data)
    );

    nvd_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(done_pulse), .waddr(wr_ptr),
        .wdata(wr_data), .raddr(ptr_q), .rdata(cell_q)
    );

    // Pointer and data registers: software writes and read fills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            data_q <= '0;
        end else begin
            if (bus_sel && bus_write && bus_addr == OFS_PTR) ptr_q <= bus_wdata[AW-1:0];
            if (bus_sel && bus_write && bus_addr == OFS_DATA) data_q <= bus_wdata;
            else if (rd_req) data_q <= cell_q;
        end
    end

    // Control/status bits: enable, interrupt enable, sticky error and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            ie_q   <= 1'b0;
            err_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                en_q <= bus_wdata[CB_EN];
                ie_q <= bus_wdata[CB_IE];
            end
            if (reject)       err_q <= 1'b1;
            else if (ctrl_wr) err_q <= err_q && bus_wdata[CB_ERR];
            if (done_pulse)   done_q <= 1'b1;
            else if (ctrl_wr) done_q <= done_q && bus_wdata[CB_DONE];
        end
    end

    // Read mux over the four register offsets.
    always_comb begin
        unique case (bus_addr)
            OFS_PTR:  bus_rdata = 8'(ptr_q);
            OFS_DATA: bus_rdata = data_q;
            OFS_CTRL: bus_rdata = {2'b00, ie_q, done_q, err_q, en_q, busy, 1'b0};
            default:  bus_rdata = 8'h00;
        endcase
    end

    // R5
    start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(en_q));

    // R6
    finish_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_q);

    // R7
    en_sw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_q) |-> $past(ctrl_wr));

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_q) |-> $past(rd_req || (bus_sel && bus_write && bus_addr == OFS_DATA)));
endmodule

// File: tb/nvd_ctrl_test.sv
module nvd_ctrl_test;
    localparam int P     = 10;
    localparam int DEPTH = 16;
    localparam int WCYC  = 5;
    localparam int GAP   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_write = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0, errors = 0;
    string cur = "R1";
    logic [7:0] last_rd;
    logic       last_irq;

    // Behavioural reference state.
    int m_mem [DEPTH];
    int m_ptr, m_data, m_en, m_busy, m_err, m_done, m_ie;
    int m_ks, m_kc, m_left, m_lp, m_ld;

    nvd_ctrl #(.DEPTH(DEPTH), .WR_CYCLES(WCYC), .STEP_GAP(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(P/2) clk = ~clk;

    task automatic expect8(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h", tag, got, exp);
        end
    endtask

    function automatic int model_rd(input int a);
        case (a)
            0: return m_ptr;
            1: return m_data;
            2: return (m_ie << 5) | (m_done << 4) | (m_err << 3) | (m_en << 2) | (m_busy << 1);
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
        m_ptr = 0; m_data = 0; m_en = 0; m_busy = 0; m_err = 0; m_done = 0; m_ie = 0;
        m_ks = 0; m_kc = 0; m_left = 0; m_lp = 0; m_ld = 0;
    endtask

    task automatic model_step(input bit s, input bit w, input int a, input int d);
        bit keyw, ctw, acc, rej, rd, fin;
        int rdval;
        keyw = s && w && a == 3;
        ctw  = s && w && a == 2;
        acc  = ctw && d[1] && m_en == 1 && m_busy == 0 && m_ks == 2 && m_kc == GAP;
        rej  = ctw && d[1] && m_busy == 0 && !acc;
        rd   = ctw && d[0] && m_busy == 0;
        rdval = m_mem[m_ptr];
        fin  = m_busy == 1 && m_left == 0;
        // key sequence
        if (m_busy == 1) m_ks = 0;
        else if (m_ks == 0) begin
            if (keyw && d == 8'h55) begin m_ks = 1; m_kc = 1; end
        end else if (m_ks == 1) begin
            if (s) begin
                if (keyw && d == 8'hAA && m_kc == GAP) begin m_ks = 2; m_kc = 1; end
                else m_ks = 0;
            end else if (m_kc >= GAP) m_ks = 0;
            else m_kc++;
        end else begin
            if (s || m_kc >= GAP) m_ks = 0;
            else m_kc++;
        end
        // write timer
        if (acc) begin m_busy = 1; m_left = WCYC - 1; m_lp = m_ptr; m_ld = m_data; end
        else if (fin) begin m_busy = 0; m_mem[m_lp] = m_ld; end
        else if (m_busy == 1) m_left--;
        // registers
        if (s && w && a == 0) m_ptr = d % DEPTH;
        if (s && w && a == 1) m_data = d;
        else if (rd) m_data = rdval;
        if (ctw) begin m_en = d[2]; m_ie = d[5]; end
        if (rej) m_err = 1; else if (ctw) m_err = m_err & d[3];
        if (fin) m_done = 1; else if (ctw) m_done = m_done & d[4];
    endtask

    // One bus clock: drive, compare against the model mid-cycle, advance.
    task automatic step(input bit s, input bit w, input int a, input int d);
        bus_sel = s; bus_write = w; bus_addr = 2'(a); bus_wdata = 8'(d);
        #(P/4);
        last_rd = bus_rdata; last_irq = irq;
        expect8({cur, " cycle rdata"}, bus_rdata, model_rd(a));
        expect8({cur, " cycle irq"}, irq, m_done & m_ie);
        @(posedge clk);
        model_step(s, w, a, d);
        @(negedge clk);
    endtask

    task automatic idle(); step(0, 0, 2, 0); endtask
    task automatic peek(input int a); step(0, 0, a, 0); endtask
    task automatic wreg(input int a, input int d); step(1, 1, a, d); endtask

    // Key sequence with legal spacing, then a control write of ctl.
    task automatic keys_then(input int ctl);
        wreg(3, 8'h55);
        for (int i = 1; i < GAP; i++) idle();
        wreg(3, 8'hAA);
        for (int i = 1; i < GAP; i++) idle();
        wreg(2, ctl);
    endtask

    task automatic do_write(input int a, input int d, input int ex);
        wreg(0, a); wreg(1, d); wreg(2, 8'h04 | ex);
        keys_then(8'h06 | ex);
    endtask

    task automatic read_cell(input int a, output int v);
        wreg(0, a); wreg(2, 8'h01); peek(1); v = last_rd;
    endtask

    task automatic wait_write(); for (int i = 0; i < WCYC + 1; i++) idle(); endtask

    initial begin
        #(P * 200000);
        errors++;
        $display("FAIL watchdog got hang expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset image
        cur = "R1";
        for (int a = 0; a < 4; a++) begin peek(a); expect8("R1 reset reg", last_rd, 0); end
        expect8("R1 irq low", last_irq, 0);
        read_cell(9, v); expect8("R1 cell cleared", v, 0);

        // R6 timing of a legal write
        cur = "R6";
        do_write(3, 8'hA5, 0);
        peek(2); expect8("R6 busy after accept", last_rd, 8'h06);
        for (int i = 0; i < WCYC - 2; i++) idle();
        peek(2); expect8("R6 busy in last clock", last_rd, 8'h06);
        peek(2); expect8("R6 done, R7 enable kept", last_rd, 8'h14);
        // R2 read back
        cur = "R2";
        wreg(0, 3); wreg(2, 8'h01);
        peek(1); expect8("R2 read next clock", last_rd, 8'hA5);
        peek(2); expect8("R2 RD reads zero", last_rd & 8'h01, 0);

        // R3 and R8
        cur = "R3";
        wreg(1, 8'h3C); peek(1); expect8("R3 sw data write", last_rd, 8'h3C);
        do_write(7, 8'h11, 0);
        cur = "R8";
        wreg(1, 8'h3C); wreg(0, 9);
        wait_write();
        peek(1); expect8("R3 data kept after write", last_rd, 8'h3C);
        read_cell(7, v); expect8("R8 captured target", v, 8'h11);
        read_cell(9, v); expect8("R8 new pointer untouched", v, 0);

        // R7 enable cleared mid-write
        cur = "R7";
        do_write(2, 8'h77, 0);
        wreg(2, 8'h00);
        wait_write();
        peek(2); expect8("R7 write finished", last_rd, 8'h10);
        read_cell(2, v); expect8("R7 cell stored", v, 8'h77);

        // R4 sequence violations, R11 error clear
        cur = "R4";
        wreg(0, 4); wreg(1, 8'h99); wreg(2, 8'h04);
        wreg(3, 8'h55); idle(); wreg(3, 8'hAB); idle(); wreg(2, 8'h06);
        peek(2); expect8("R4 wrong key rejected", last_rd, 8'h0C);
        cur = "R11";
        wreg(2, 8'h04); peek(2); expect8("R11 error cleared", last_rd, 8'h04);
        cur = "R4";
        wreg(3, 8'h55); wreg(3, 8'hAA); idle(); wreg(2, 8'h06);
        peek(2); expect8("R4 early key rejected", last_rd, 8'h0C);
        wreg(2, 8'h0C); peek(2); expect8("R11 write 1 keeps error", last_rd, 8'h0C);
        wreg(2, 8'h04);
        wreg(3, 8'h55); step(1, 0, 0, 0); wreg(3, 8'hAA); idle(); wreg(2, 8'h06);
        peek(2); expect8("R4 interposed access rejected", last_rd, 8'h0C);
        wreg(2, 8'h04);
        wreg(3, 8'h55); idle(); wreg(3, 8'hAA); idle(); idle(); wreg(2, 8'h06);
        peek(2); expect8("R4 late request rejected", last_rd, 8'h0C);
        wait_write();
        read_cell(4, v); expect8("R4 cell unchanged", v, 0);

        // R5 enable not set
        cur = "R5";
        wreg(0, 4); wreg(1, 8'h99); wreg(2, 8'h00);
        keys_then(8'h06);
        peek(2); expect8("R5 no enable rejected", last_rd, 8'h0C);
        wait_write();
        read_cell(4, v); expect8("R5 cell unchanged", v, 0);

        // R9 RD and keys ignored while writing
        cur = "R9";
        do_write(5, 8'h42, 0);
        wreg(0, 3); wreg(2, 8'h05);
        peek(1); expect8("R9 RD ignored while busy", last_rd, 8'h42);
        wreg(3, 8'h55); idle(); wreg(3, 8'hAA); idle(); wreg(2, 8'h06);
        peek(2); expect8("R9 keys during write not kept", last_rd & 8'h0A, 8'h08);
        wait_write();
        read_cell(5, v); expect8("R9 cell stored", v, 8'h42);
        read_cell(3, v); expect8("R9 other cell intact", v, 8'hA5);

        // R10 interrupt
        cur = "R10";
        do_write(6, 8'h5A, 8'h20);
        wait_write();
        peek(2); expect8("R10 irq raised", last_irq, 1);
        wreg(2, 8'h34); peek(2); expect8("R10 done kept", last_irq, 1);
        wreg(2, 8'h24); peek(2); expect8("R10 done cleared", last_rd, 8'h24);
        expect8("R10 irq low", last_irq, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule